// File: doc/BRIEF.md
# Block Floating Point Normalizer

This unit rescales a group of two's complement mantissas that all share a single exponent. The group arrives one sample at a time over a valid/ready stream. Upstream fixed-point arithmetic runs on the group without normalizing after each operation, and the group is renormalized once at the end. The unit stores the samples while it measures headroom. It then sends the same samples out again, each shifted left by one common amount, together with the exponent reduced by that amount.

The common shift is the smallest count of redundant sign bits found in the group, which is the count that belongs to the element of largest magnitude. Because the scaling depends on the data, the output pass starts only after the input pass has seen every element. The input pass ends at an element flagged as the last one, or when the buffer is full, whichever comes first. While the output pass runs the input side refuses new data.

Top module: `bfp_normalizer`

## Requirements
- R1: During reset and in the first cycle after it, `in_ready` is 1 and `out_valid` is 0. A reset applied during an output pass discards the pending group.
- R2: `in_ready` and `out_valid` are never 1 at the same time. While a group is being output, input beats are refused and have no effect on the outputs, on the current group or on the next group.
- R3: The redundant sign count of a mantissa is the number of bits directly below the MSB, taken in a run, that equal the MSB. The applied shift is the minimum of this count over the group, and each output mantissa equals its input mantissa shifted left by that amount, with zeros filling in from the LSB.
- R4: `out_exp` equals the group exponent minus the applied shift. The group exponent is an unsigned code.
- R5: If the minimum redundant sign count exceeds the group exponent, the applied shift is limited to the group exponent and `out_exp` is 0. The exponent never wraps.
- R6: A group whose elements are all zero is output as zeros with `out_exp` equal to the group exponent, which means a shift of 0.
- R7: No output mantissa has a sign bit that differs from the sign bit of its input.
- R8: A beat with `in_last`=1 closes the group. The output pass then produces exactly as many beats as were accepted, in arrival order, with `out_last`=1 on the final beat only. The input pass can accept data again in the cycle after that final beat.
- R9: If `MAX_LEN` beats arrive without `in_last`, the `MAX_LEN`-th beat closes the group.
- R10: While `out_valid`=1 and `out_ready`=0, the values of `out_mant`, `out_exp` and `out_last` stay the same in the next cycle.
- R11: The group exponent is the `in_exp` value of the group's first beat. The `in_exp` values of the later beats are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be accepted (input pass) |
| in_mant | input | MANT_W | Two's complement mantissa of the element |
| in_exp | input | EXP_W | Shared exponent, taken from the group's first beat |
| in_last | input | 1 | Marks the final element of the group |
| out_valid | output | 1 | Scaled beat offered (output pass) |
| out_ready | input | 1 | Downstream accepts the scaled beat |
| out_mant | output | MANT_W | Element shifted by the common amount |
| out_exp | output | EXP_W | Adjusted shared exponent |
| out_last | output | 1 | Marks the final scaled element |

## Verification
The hardest cases to reach are the ones that depend on how the whole group turns out: the saturating exponent, the all-zero group, and groups in which the element of largest magnitude is negative, such as -1 or a negative power of two. Each of these needs a full group built so that the minimum sign count and the exponent relate in a chosen way. Vector-table rows cover each case: the shift is limited by the exponent, the shift lands exactly on exponent 0, a positive and a negative element tie, and the group is all zeros. Directed tests cover the rest. One fills the buffer without `in_last`. One pushes beats during a stalled output pass. One applies reset in the middle of an output pass. Every beat after the first carries a deliberately wrong `in_exp`.

// File: rtl/bfp_pkg.sv
// Shared types for the block floating point normalizer.
// Assumes: nothing beyond the two pass phases of the top module.
package bfp_pkg;

    // Phase of the normalizer: collecting a group or emitting it.
    typedef enum logic {
        PH_FILL  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_t;

endpackage

// File: rtl/bfp_sign_count.sv
// Counts the redundant sign bits of a two's complement word: the run of bits
// directly below the MSB that equal the MSB. Purely combinational.
// Assumes MANT_W >= 2; result ranges 0 .. MANT_W-1.
module bfp_sign_count #(
    parameter int MANT_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic [MANT_W-1:0] mant,
    output logic [CNT_W-1:0]  count
);

    // Walk from MSB-1 downward while the bits match the sign.
    always_comb begin
        logic run;
        count = '0;
        run   = 1'b1;
        for (int i = MANT_W - 2; i >= 0; i--) begin
            if (run && (mant[i] == mant[MANT_W-1])) begin
                count = count + CNT_W'(1);
            end else begin
                run = 1'b0;
            end
        end
    end

endmodule

// File: rtl/bfp_block_store.sv
// Register array holding one group of mantissas between the two passes.
// One write port, one combinational read port. Data words carry no reset;
// they are always written before they are read.
module bfp_block_store #(
    parameter int MANT_W = 16,
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [MANT_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [MANT_W-1:0] rd_data
);

    logic [MANT_W-1:0] mem [DEPTH];

    // Capture an incoming element into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Present the element selected by the read index.
    always_comb begin
        rd_data = mem[rd_idx];
    end

endmodule

// File: rtl/bfp_barrel.sv
// Logarithmic left shifter: stage k moves the word by 2**k when amount[k]
// is set, filling zeros from the LSB. Assumes the caller keeps the amount
// within the headroom, so no significant bit is lost off the top.
module bfp_barrel #(
    parameter int MANT_W = 16,
    parameter int SH_W   = 4
) (
    input  logic [MANT_W-1:0] din,
    input  logic [SH_W-1:0]   amount,
    output logic [MANT_W-1:0] dout
);

    logic [MANT_W-1:0] stage [SH_W+1];

    assign stage[0] = din;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        // One conditional power-of-two shift per bit of the amount.
        always_comb begin
            stage[k+1] = amount[k] ? (stage[k] << (2 ** k)) : stage[k];
        end
    end

    assign dout = stage[SH_W];

endmodule

// File: rtl/bfp_scale_ctrl.sv
// Turns the group's headroom into the applied shift and the new exponent.
// An all-zero group gets a shift of 0. A shift larger than the exponent is
// limited to the exponent, so the exponent stops at 0 instead of wrapping.
module bfp_scale_ctrl #(
    parameter int EXP_W = 4,
    parameter int SH_W  = 4
) (
    input  logic [SH_W-1:0]  min_cls,
    input  logic             nonzero,
    input  logic [EXP_W-1:0] base_exp,
    output logic [SH_W-1:0]  shift,
    output logic [EXP_W-1:0] new_exp
);

    localparam int CW = ((EXP_W > SH_W) ? EXP_W : SH_W) + 1;

    logic [CW-1:0] want;
    logic [CW-1:0] have;
    logic [CW-1:0] used;

    // Pick the shift: none for zeros, otherwise headroom limited by exponent.
    always_comb begin
        want = nonzero ? CW'(min_cls) : '0;
        have = CW'(base_exp);
        used = (want > have) ? have : want;
        shift   = SH_W'(used);
        new_exp = EXP_W'(have - used);
    end

endmodule

// File: rtl/bfp_normalizer.sv
// Block floating point normalizer. Input pass: accepts a group of two's
// complement mantissas, stores them and tracks the smallest redundant sign
// count. Output pass: replays the group shifted by one common amount with
// the reduced shared exponent. The group exponent comes from the first beat.
// Assumes MAX_LEN >= 2 and MANT_W >= 2.
module bfp_normalizer #(
    parameter int MANT_W  = 16,
    parameter int EXP_W   = 4,
    parameter int MAX_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [MANT_W-1:0] in_mant,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [MANT_W-1:0] out_mant,
    output logic [EXP_W-1:0]  out_exp,
    output logic              out_last
);

    import bfp_pkg::*;

    localparam int IDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
    localparam int SH_W  = (MANT_W > 1) ? $clog2(MANT_W) : 1;
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(MAX_LEN - 1);

    phase_t            phase_q;
    logic [IDX_W-1:0]  wr_idx_q;
    logic [IDX_W-1:0]  rd_idx_q;
    logic [IDX_W-1:0]  end_idx_q;
    logic [SH_W-1:0]   min_cls_q;
    logic              nz_q;
    logic [EXP_W-1:0]  base_exp_q;
    logic [SH_W-1:0]   shift_q;
    logic [EXP_W-1:0]  exp_out_q;

    logic              accept;
    logic              emit;
    logic              first_beat;
    logic              closing;
    logic [SH_W-1:0]   cls_in;
    logic [SH_W-1:0]   min_cls_nx;
    logic              nz_nx;
    logic [EXP_W-1:0]  base_exp_nx;
    logic [SH_W-1:0]   shift_nx;
    logic [EXP_W-1:0]  exp_nx;
    logic [MANT_W-1:0] rd_mant;

    assign in_ready   = (phase_q == PH_FILL);
    assign out_valid  = (phase_q == PH_DRAIN);
    assign accept     = in_valid && in_ready;
    assign emit       = out_valid && out_ready;
    assign first_beat = (wr_idx_q == '0);
    assign closing    = accept && (in_last || (wr_idx_q == LAST_SLOT));

    bfp_sign_count #(
        .MANT_W (MANT_W),
        .CNT_W  (SH_W)
    ) u_cls (
        .mant  (in_mant),
        .count (cls_in)
    );

    // Fold the arriving element into the running group statistics.
    always_comb begin
        if (first_beat) begin
            min_cls_nx  = cls_in;
            nz_nx       = (in_mant != '0);
            base_exp_nx = in_exp;
        end else begin
            min_cls_nx  = (cls_in < min_cls_q) ? cls_in : min_cls_q;
            nz_nx       = nz_q || (in_mant != '0);
            base_exp_nx = base_exp_q;
        end
    end

    bfp_scale_ctrl #(
        .EXP_W (EXP_W),
        .SH_W  (SH_W)
    ) u_ctrl (
        .min_cls  (min_cls_nx),
        .nonzero  (nz_nx),
        .base_exp (base_exp_nx),
        .shift    (shift_nx),
        .new_exp  (exp_nx)
    );

    bfp_block_store #(
        .MANT_W (MANT_W),
        .DEPTH  (MAX_LEN),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (accept),
        .wr_idx  (wr_idx_q),
        .wr_data (in_mant),
        .rd_idx  (rd_idx_q),
        .rd_data (rd_mant)
    );

    // Phase sequencing and write/read indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_FILL;
            wr_idx_q  <= '0;
            rd_idx_q  <= '0;
            end_idx_q <= '0;
        end else if (phase_q == PH_FILL) begin
            if (closing) begin
                phase_q   <= PH_DRAIN;
                end_idx_q <= wr_idx_q;
                wr_idx_q  <= '0;
                rd_idx_q  <= '0;
            end else if (accept) begin
                wr_idx_q <= wr_idx_q + IDX_W'(1);
            end
        end else if (emit) begin
            if (rd_idx_q == end_idx_q) begin
                phase_q  <= PH_FILL;
                rd_idx_q <= '0;
            end else begin
                rd_idx_q <= rd_idx_q + IDX_W'(1);
            end
        end
    end

    // Group statistics and the frozen scaling for the output pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_cls_q  <= '0;
            nz_q       <= 1'b0;
            base_exp_q <= '0;
            shift_q    <= '0;
            exp_out_q  <= '0;
        end else if (accept) begin
            min_cls_q  <= min_cls_nx;
            nz_q       <= nz_nx;
            base_exp_q <= base_exp_nx;
            if (closing) begin
                shift_q   <= shift_nx;
                exp_out_q <= exp_nx;
            end
        end
    end

    bfp_barrel #(
        .MANT_W (MANT_W),
        .SH_W   (SH_W)
    ) u_shift (
        .din    (rd_mant),
        .amount (shift_q),
        .dout   (out_mant)
    );

    assign out_exp  = exp_out_q;
    assign out_last = out_valid && (rd_idx_q == end_idx_q);

endmodule

// File: rtl/bfp_normalizer_chk.sv
// Protocol and scaling properties of the normalizer, bound to the top module.
module bfp_normalizer_chk #(
    parameter int MANT_W = 16,
    parameter int EXP_W  = 4,
    parameter int SH_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [MANT_W-1:0] out_mant,
    input logic [EXP_W-1:0]  out_exp,
    input logic              out_last,
    input logic [MANT_W-1:0] rd_mant,
    input logic [SH_W-1:0]   shift_amt,
    input logic [EXP_W-1:0]  base_exp
);

    // R2: the two passes never overlap.
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R4: the exponent drops by exactly the applied shift.
    a_r4_exp_delta: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_exp) + int'(shift_amt) == int'(base_exp)));

    // R7: the shifter output keeps the sign of the stored element.
    a_r7_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mant[MANT_W-1] == rd_mant[MANT_W-1]));

    // R8: the input side reopens right after the final output beat.
    a_r8_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> in_ready);

    // R10: a stalled output holds its values.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_mant) && $stable(out_exp) && $stable(out_last)));

endmodule

bind bfp_normalizer bfp_normalizer_chk #(
    .MANT_W (MANT_W),
    .EXP_W  (EXP_W),
    .SH_W   (SH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_mant  (out_mant),
    .out_exp   (out_exp),
    .out_last  (out_last),
    .rd_mant   (rd_mant),
    .shift_amt (shift_q),
    .base_exp  (base_exp_q)
);

// File: tb/bfp_normalizer_tb.sv
module bfp_normalizer_tb;

    localparam int MW = 16;
    localparam int EW = 4;
    localparam int ML = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [MW-1:0] in_mant = '0;
    logic [EW-1:0] in_exp = '0;
    logic          in_last = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [MW-1:0] out_mant;
    logic [EW-1:0] out_exp;
    logic          out_last;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bfp_normalizer #(
        .MANT_W  (MW),
        .EXP_W   (EW),
        .MAX_LEN (ML)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_mant   (in_mant),
        .in_exp    (in_exp),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_mant  (out_mant),
        .out_exp   (out_exp),
        .out_last  (out_last)
    );

    // Group length, group exponent, four mantissas, expected shift, expected exponent.
    typedef struct packed {
        logic [2:0]  len;
        logic [3:0]  ex;
        logic [15:0] m0;
        logic [15:0] m1;
        logic [15:0] m2;
        logic [15:0] m3;
        logic [3:0]  sh;
        logic [3:0]  eo;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{3'd4, 4'd12, 16'h0010, 16'hFFF0, 16'h0003, 16'h0000, 4'd10, 4'd2},  // R3 R4 mixed signs
        '{3'd3, 4'd5,  16'h4000, 16'h1234, 16'h8000, 16'h0000, 4'd0,  4'd5},  // R3 no headroom
        '{3'd2, 4'd3,  16'h0001, 16'h0002, 16'h0000, 16'h0000, 4'd3,  4'd0},  // R5 saturation
        '{3'd4, 4'd7,  16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'd0,  4'd7},  // R6 all zero
        '{3'd1, 4'd15, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 4'd15, 4'd0},  // R7 minus one
        '{3'd2, 4'd9,  16'hFF80, 16'h007F, 16'h0000, 16'h0000, 4'd8,  4'd1},  // R3 tie
        '{3'd3, 4'd6,  16'h0100, 16'hFE00, 16'h0050, 16'h0000, 4'd6,  4'd0}   // R4 exact to zero
    };

    function automatic logic [15:0] pick(input vec_t v, input int k);
        case (k)
            0: pick = v.m0;
            1: pick = v.m1;
            2: pick = v.m2;
            default: pick = v.m3;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    // Offer one beat at a falling edge; it is taken at the next rising edge.
    task automatic send_beat(input logic [MW-1:0] m, input logic [EW-1:0] e, input logic l);
        in_valid = 1'b1;
        in_mant  = m;
        in_exp   = e;
        in_last  = l;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Check the beat on offer, then accept it.
    task automatic recv_beat(input logic [MW-1:0] m, input logic [EW-1:0] e,
                             input logic l, input string tag);
        check(out_valid == 1'b1, {tag, " out_valid"}, 32'(out_valid), 32'd1);
        check(out_mant == m, {tag, " out_mant"}, 32'(out_mant), 32'(m));
        check(out_exp == e, {tag, " out_exp"}, 32'(out_exp), 32'(e));
        check(out_last == l, {tag, " out_last"}, 32'(out_last), 32'(l));
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input string tag);
        for (int k = 0; k < int'(v.len); k++) begin
            // R11: only the first beat carries the real exponent.
            send_beat(pick(v, k), (k == 0) ? v.ex : ~v.ex, (k == int'(v.len) - 1));
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        check(in_ready == 1'b0, {tag, " R2 in_ready low"}, 32'(in_ready), 32'd0);
        for (int k = 0; k < int'(v.len); k++) begin
            recv_beat(pick(v, k) << v.sh, v.eo, (k == int'(v.len) - 1), tag);
        end
        check(in_ready == 1'b1, {tag, " R8 reopen"}, 32'(in_ready), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R1 in_ready in reset", 32'(in_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);

        // Table of vectors: R3 R4 R5 R6 R7 R8 R11
        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i], $sformatf("vec%0d R3/R11", i));
        end

        // R9: a full buffer closes the group without in_last
        for (int k = 0; k < ML; k++) begin
            send_beat(16'(k + 1), (k == 0) ? 4'd15 : 4'd2, 1'b0);
        end
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R9 forced close", 32'(out_valid), 32'd1);
        for (int k = 0; k < ML; k++) begin
            recv_beat(16'(k + 1) << 11, 4'd4, (k == ML - 1), "R9 full group");
        end

        // R10 and R2: stall the output pass while offering input beats
        send_beat(16'h0010, 4'd12, 1'b0);
        send_beat(16'hFFF0, 4'd0, 1'b1);
        in_valid = 1'b1;
        in_mant  = 16'h0001;
        in_exp   = 4'd1;
        in_last  = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk);
            @(negedge clk);
            check(out_mant == 16'h4000, "R10 held mant", 32'(out_mant), 32'h4000);
            check(in_ready == 1'b0, "R2 refused during output", 32'(in_ready), 32'd0);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        recv_beat(16'h4000, 4'd2, 1'b0, "R2 stalled group");
        recv_beat(16'hC000, 4'd2, 1'b1, "R2 stalled group");
        // R2: the refused beats did not leak into the next group
        run_vec(VEC[1], "R2 next group");

        // R1: reset in the middle of an output pass
        send_beat(16'h0100, 4'd9, 1'b1);
        in_valid = 1'b0;
        in_last  = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(out_valid == 1'b0, "R1 drain reset out_valid", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R1 drain reset in_ready", 32'(in_ready), 32'd1);
        run_vec(VEC[2], "R1 after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule